// File: doc/BRIEF.md
# Downward-Growing Hardware Stack Unit

This block keeps a byte-wide stack in a small data RAM and owns the stack pointer for a simple 8-bit processor. It serves four kinds of request. A push stores one register byte on the stack, and a pop returns one byte from it. A call saves a multi-byte return address and hands back the jump target. A return takes the saved address off the stack and hands it back as the new program counter.

The pointer starts at the highest RAM address, and the stack grows toward address zero. Every RAM byte reads as zero after reset. A request is taken only while the unit is idle. The request then runs for one clock per byte it moves, and a one-cycle done strobe marks its end.

Top module: `stack_unit`

## Requirements
- R1: After reset the stack pointer `sp` equals RAM_BYTES-1 (0x7FF for the default 2048 bytes), and `busy` and `done` are low.
- R2: A pop of a RAM location that has not been written since reset returns 0x00.
- R3: A push (req_op = 2'b00) writes `req_data` at the current `sp` and then lowers `sp` by one.
- R4: A pop (req_op = 2'b01) first raises `sp` by one and then returns the byte at the new `sp` on `pop_data`. All pointer arithmetic wraps modulo RAM_BYTES.
- R5: A call (req_op = 2'b10) writes the low byte of `req_ret` at `sp` and the high byte at `sp`-1, leaves `sp` two lower, and drives `req_target` on `pc_out`.
- R6: A return (req_op = 2'b11) pops the high byte first and then the low byte, leaves `sp` two higher, and drives the restored 16-bit address on `pc_out`.
- R7: `done` is high for exactly one cycle, N clock edges after the edge that accepts the request, where N is the number of bytes moved (1 for push and pop, 2 for call and return). `busy` is high from the accepting edge until that strobe.
- R8: A request presented while `busy` is high is ignored. It changes neither the stack contents nor `sp`.
- R9: `pop_data` changes only on a pop, and `pc_out` changes only on a call or a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 00 push, 01 pop, 10 call, 11 return |
| req_data | input | 8 | Byte to push |
| req_ret | input | PC_W | Return address saved by a call |
| req_target | input | PC_W | Jump target of a call |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| pop_data | output | 8 | Last popped byte |
| pc_out | output | PC_W | Jump target or restored address |
| sp | output | $clog2(RAM_BYTES) | Stack pointer |

## Verification
The bench pops from a fresh stack, where the pointer wraps from the top address to zero and must return a zero byte. A design without a zeroed RAM would return stale data there, and one that clamps the pointer would read the wrong place. Nested frames of calls and pushes catch a byte order swapped between call and return, which would return an address with its halves exchanged. A request held high through a busy window catches a design that accepts it anyway, which would move `sp` by extra bytes. Done-strobe timing is counted per operation, so an extra or missing cycle shows up as a late, early or stretched strobe.

// File: rtl/stack_pkg.sv
package stack_pkg;
    typedef enum logic [1:0] {
        OP_PUSH = 2'b00,
        OP_POP  = 2'b01,
        OP_CALL = 2'b10,
        OP_RET  = 2'b11
    } stk_op_e;
endpackage

// File: rtl/stack_ram.sv
module stack_ram #(
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem_q [DEPTH];

    // Zero-initialised byte array: reset clears every location (R2)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
    import stack_pkg::*;
#(
    parameter int RAM_BYTES = 2048,
    parameter int PC_W      = 16,
    parameter int ADDR_W    = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [7:0]        req_data,
    input  logic [PC_W-1:0]   req_ret,
    input  logic [PC_W-1:0]   req_target,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic [7:0]        ram_wdata,
    output logic [ADDR_W-1:0] ram_raddr,
    input  logic [7:0]        ram_rdata,
    output logic              busy_o,
    output logic              done_o,
    output logic [7:0]        pop_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [ADDR_W-1:0] sp_o
);
    localparam int NBYTES = PC_W / 8;
    localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(NBYTES - 1);
    localparam logic [ADDR_W-1:0] SP_TOP   = ADDR_W'(RAM_BYTES - 1);
    localparam logic [ADDR_W-1:0] SP_ONE   = ADDR_W'(1);

    typedef struct packed {
        logic              busy;
        stk_op_e           op;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] sp;
        logic [7:0]        data;
        logic [PC_W-1:0]   ret;
        logic [PC_W-1:0]   tgt;
        logic [7:0]        pop;
        logic [PC_W-1:0]   pc;
        logic              done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        ram_we    = 1'b0;
        ram_waddr = st_q.sp;
        ram_wdata = 8'h00;
        ram_raddr = st_q.sp + SP_ONE;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy = 1'b1;
                st_d.op   = stk_op_e'(req_op);
                st_d.cnt  = '0;
                st_d.data = req_data;
                st_d.ret  = req_ret;
                st_d.tgt  = req_target;
            end
        end else begin
            case (st_q.op)
                OP_PUSH: begin
                    ram_we    = 1'b1;
                    ram_wdata = st_q.data;
                    st_d.sp   = st_q.sp - SP_ONE;
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
                OP_POP: begin
                    st_d.sp   = st_q.sp + SP_ONE;
                    st_d.pop  = ram_rdata;
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
                OP_CALL: begin
                    // low byte goes first, so it ends at the higher address
                    ram_we    = 1'b1;
                    ram_wdata = st_q.ret[st_q.cnt*8 +: 8];
                    st_d.sp   = st_q.sp - SP_ONE;
                    st_d.cnt  = st_q.cnt + 1'b1;
                    if (st_q.cnt == LAST_CNT) begin
                        st_d.pc   = st_q.tgt;
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                    end
                end
                default: begin
                    // return: highest byte comes off first
                    st_d.sp  = st_q.sp + SP_ONE;
                    st_d.ret[(LAST_CNT - st_q.cnt)*8 +: 8] = ram_rdata;
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == LAST_CNT) begin
                        st_d.pc   = st_d.ret;
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.sp <= SP_TOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign pop_o  = st_q.pop;
    assign pc_o   = st_q.pc;
    assign sp_o   = st_q.sp;

    p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.op == OP_PUSH) |=> (st_q.sp == $past(st_q.sp) - SP_ONE));

    p_pop_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.op == OP_POP) |=> (st_q.sp == $past(st_q.sp) + SP_ONE));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> ($stable(st_q.op) && $stable(st_q.data) && $stable(st_q.tgt)));

    p_idle_sp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |=> $stable(st_q.sp));

    p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o || st_q.op inside {OP_PUSH, OP_POP}) |=> (done_o || $stable(pc_o)));
endmodule

// File: rtl/stack_unit.sv
module stack_unit #(
    parameter int RAM_BYTES = 2048,
    parameter int PC_W      = 16,
    parameter int ADDR_W    = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [7:0]        req_data,
    input  logic [PC_W-1:0]   req_ret,
    input  logic [PC_W-1:0]   req_target,
    output logic              busy,
    output logic              done,
    output logic [7:0]        pop_data,
    output logic [PC_W-1:0]   pc_out,
    output logic [ADDR_W-1:0] sp
);
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [7:0]        ram_wdata;
    logic [ADDR_W-1:0] ram_raddr;
    logic [7:0]        ram_rdata;

    stack_ctrl #(.RAM_BYTES(RAM_BYTES), .PC_W(PC_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_data   (req_data),
        .req_ret    (req_ret),
        .req_target (req_target),
        .ram_we     (ram_we),
        .ram_waddr  (ram_waddr),
        .ram_wdata  (ram_wdata),
        .ram_raddr  (ram_raddr),
        .ram_rdata  (ram_rdata),
        .busy_o     (busy),
        .done_o     (done),
        .pop_o      (pop_data),
        .pc_o       (pc_out),
        .sp_o       (sp)
    );

    stack_ram #(.DEPTH(RAM_BYTES), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    p_write_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> busy);
endmodule

// File: tb/stack_unit_tb.sv
module stack_unit_tb;
    localparam int RAM_BYTES = 2048;
    localparam int AW        = $clog2(RAM_BYTES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [7:0]    req_data = 8'h00;
    logic [15:0]   req_ret = 16'h0;
    logic [15:0]   req_target = 16'h0;
    logic          busy, done;
    logic [7:0]    pop_data;
    logic [15:0]   pc_out;
    logic [AW-1:0] sp;

    int checks = 0;
    int fails  = 0;

    logic [7:0]    m_mem [RAM_BYTES];
    logic [AW-1:0] m_sp;
    logic [7:0]    m_pop;
    logic [15:0]   m_pc;

    always #10 clk = ~clk;

    stack_unit #(.RAM_BYTES(RAM_BYTES), .PC_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .req_ret(req_ret), .req_target(req_target),
        .busy(busy), .done(done), .pop_data(pop_data), .pc_out(pc_out), .sp(sp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int op_bytes(input logic [1:0] op);
        return (op[1]) ? 2 : 1;
    endfunction

    // reference model of one operation
    task automatic model(input logic [1:0] op, input logic [7:0] d,
                         input logic [15:0] r, input logic [15:0] t);
        case (op)
            2'b00: begin m_mem[m_sp] = d; m_sp = m_sp - 1'b1; end
            2'b01: begin m_sp = m_sp + 1'b1; m_pop = m_mem[m_sp]; end
            2'b10: begin
                m_mem[m_sp] = r[7:0];  m_sp = m_sp - 1'b1;
                m_mem[m_sp] = r[15:8]; m_sp = m_sp - 1'b1;
                m_pc = t;
            end
            default: begin
                m_sp = m_sp + 1'b1; m_pc[15:8] = m_mem[m_sp];
                m_sp = m_sp + 1'b1; m_pc[7:0]  = m_mem[m_sp];
            end
        endcase
    endtask

    task automatic do_op(input logic [1:0] op, input logic [7:0] d,
                         input logic [15:0] r, input logic [15:0] t, input bit inject);
        int n;
        n = op_bytes(op);
        req_valid = 1'b1; req_op = op; req_data = d; req_ret = r; req_target = t;
        model(op, d, r, t);
        for (int k = 1; k <= n + 1; k++) begin
            @(negedge clk);
            if (inject) begin
                // R8: keep a different request asserted during the busy window
                req_valid = 1'b1; req_op = ~op; req_data = ~d; req_ret = ~r; req_target = ~t;
            end else begin
                req_valid = 1'b0;
            end
            if (k <= n) begin
                check("R7 busy during op", {31'd0, busy}, 32'd1);
                check("R7 no early done", {31'd0, done}, 32'd0);
            end else begin
                req_valid = 1'b0;
                check("R7 done on time", {31'd0, done}, 32'd1);
            end
        end
        check("R3 R4 R5 R6 sp", {{(32-AW){1'b0}}, sp}, {{(32-AW){1'b0}}, m_sp});
        check("R4 R9 pop_data", {24'd0, pop_data}, {24'd0, m_pop});
        check("R5 R6 R9 pc_out", {16'd0, pc_out}, {16'd0, m_pc});
        @(negedge clk);
        check("R7 done single cycle", {31'd0, done}, 32'd0);
        check("R7 idle after done", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < RAM_BYTES; i++) m_mem[i] = 8'h00;
        m_sp = AW'(RAM_BYTES - 1); m_pop = 8'h00; m_pc = 16'h0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 sp reset", {{(32-AW){1'b0}}, sp}, 32'h7FF);
        check("R1 busy reset", {31'd0, busy}, 32'd0);
        check("R1 done reset", {31'd0, done}, 32'd0);

        // R2: pop on a fresh stack wraps to address 0, never written
        do_op(2'b01, 8'h00, 16'h0, 16'h0, 1'b0);
        check("R2 zero read", {24'd0, pop_data}, 32'd0);
        // R3/R4 wrap back: push refills address 0, sp returns to top
        do_op(2'b00, 8'h5A, 16'h0, 16'h0, 1'b0);
        check("R1 R3 sp back at top", {{(32-AW){1'b0}}, sp}, 32'h7FF);

        // nested frames: R3 R5 R4 R6
        do_op(2'b00, 8'hA1, 16'h0, 16'h0, 1'b0);
        do_op(2'b10, 8'h00, 16'h1234, 16'h0400, 1'b0);
        check("R5 target", {16'd0, pc_out}, 32'h0400);
        do_op(2'b00, 8'hB2, 16'h0, 16'h0, 1'b0);
        do_op(2'b10, 8'h00, 16'hBEEF, 16'h0800, 1'b1);
        do_op(2'b11, 8'h00, 16'h0, 16'h0, 1'b0);
        check("R6 restored inner", {16'd0, pc_out}, 32'hBEEF);
        do_op(2'b01, 8'h00, 16'h0, 16'h0, 1'b1);
        check("R4 pop B2", {24'd0, pop_data}, 32'hB2);
        do_op(2'b11, 8'h00, 16'h0, 16'h0, 1'b0);
        check("R6 restored outer", {16'd0, pc_out}, 32'h1234);
        do_op(2'b01, 8'h00, 16'h0, 16'h0, 1'b0);
        check("R4 pop A1", {24'd0, pop_data}, 32'hA1);
        check("R8 sp after injected requests", {{(32-AW){1'b0}}, sp}, 32'h7FF);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0] op;
            op = 2'($urandom_range(0, 3));
            do_op(op, 8'($urandom), 16'($urandom), 16'($urandom), ($urandom_range(0, 3) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule